// File: doc/BRIEF.md
# Timer-Triggered Pattern Output Unit

This block drives a 16-bit output pattern from a double-buffered register set. Software loads the next pattern into the next-data registers ahead of time. When a timer compare-match strobe arrives, the new value moves into the port data register, which drives the output directly. Only bits whose enable is set take part in the transfer.

The 16 outputs form four groups of four bits. Each group has its own 2-bit trigger select field, which chooses one of four compare-match strobe inputs. Groups can therefore step on different timer events, or several groups can share one event.

A small register bus reads and writes every register, and read data returns one cycle after the request. A standby input freezes the unit. While standby is high, all register contents are kept and nothing changes.

Top module: `cmp_pattern_out`

## Requirements
- R1: Reset (rstN low) clears the next-data, enable, trigger-control and port data registers to zero, so patOut reads 0x0000.
- R2: When the strobe selected for a bit's group is high and that bit's enable is 1, on the next clock edge patOut[i] takes next-data bit i. The next-data and enable registers are split by byte: address 0 and address 2 hold bits 7:0, and address 1 and address 3 hold bits 15:8.
- R3: A bit whose enable is 0 gets no transfer on its group's strobe. Its output keeps its value.
- R4: The trigger-control register (address 4) holds a select field for each group g in bits [2g+1:2g]. The field gives the index of the cmpStrobe bit that fires group g, which covers patOut[4g+3:4g]. A strobe that no group selects changes nothing.
- R5: Register addresses: 0/1 next-data low/high, 2/3 enable low/high, 4 trigger control, 5/6 port data low/high, 7 reads 0x00. A read (busSel=1, busWr=0) returns the register's contents on busRdata one cycle later, and busRdata holds that value until the next read.
- R6: A write to port data (address 5 or 6) sets the bits of that byte that get no transfer in the same cycle. Enabled bits whose group fires in that cycle take their next-data value instead.
- R7: While standby is high, bus writes and compare-match strobes have no effect. All registers keep their contents during standby and after it ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| standby | input | 1 | Freezes all register updates while high |
| busSel | input | 1 | Bus access request |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 3 | Register address |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, valid one cycle after a read |
| cmpStrobe | input | 4 | One-cycle compare-match strobes |
| patOut | output | 16 | Pattern output (port data register) |

## Verification
The assertions assume that cmpStrobe arrives as single-cycle pulses, that every bus access lasts exactly one cycle, and that inputs change only between clock edges. The bench drives all inputs on the falling edge and raises each strobe for one cycle. It issues at most one bus access per cycle. It samples the output on the falling edge after the edge that updates it. Only the collision case drives a strobe and a port write in the same cycle, and it does so on purpose.

// File: rtl/cmp_pattern_pkg.sv
package cmp_pattern_pkg;
  localparam int N_BITS   = 16;
  localparam int BYTE_W   = 8;
  localparam int N_BYTES  = N_BITS / BYTE_W;
  localparam int GRP_W    = 4;
  localparam int N_GROUPS = N_BITS / GRP_W;
  localparam int N_STROBE = 4;
  localparam int SEL_W    = $clog2(N_STROBE);
  localparam int ADDR_W   = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_NEXT_LO = 3'd0,
    RA_NEXT_HI = 3'd1,
    RA_EN_LO   = 3'd2,
    RA_EN_HI   = 3'd3,
    RA_TRIG    = 3'd4,
    RA_PORT_LO = 3'd5,
    RA_PORT_HI = 3'd6,
    RA_NONE    = 3'd7
  } regAddrE;

  // strobes from control to datapath
  typedef struct packed {
    logic [N_BYTES-1:0]  wrNext;
    logic [N_BYTES-1:0]  wrEn;
    logic [N_BYTES-1:0]  wrPort;
    logic                rdStb;
    logic [N_GROUPS-1:0] grpFire;
  } ctrlStbT;
endpackage

// File: rtl/cmp_pattern_ctrl.sv
module cmp_pattern_ctrl
  import cmp_pattern_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      standby,
  input  logic                      busSel,
  input  logic                      busWr,
  input  logic [ADDR_W-1:0]         busAddr,
  input  logic [BYTE_W-1:0]         busWdata,
  input  logic [N_STROBE-1:0]       cmpStrobe,
  output ctrlStbT                   stb,
  output logic [N_GROUPS*SEL_W-1:0] trigCtl
);
  logic    live;
  logic    wrAcc;
  regAddrE addr;

  assign live  = !standby;
  assign wrAcc = busSel && busWr && live;
  assign addr  = regAddrE'(busAddr);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trigCtl <= '0;
    end else if (wrAcc && addr == RA_TRIG) begin
      trigCtl <= busWdata[N_GROUPS*SEL_W-1:0];
    end
  end

  assign stb.wrNext = {wrAcc && addr == RA_NEXT_HI, wrAcc && addr == RA_NEXT_LO};
  assign stb.wrEn   = {wrAcc && addr == RA_EN_HI,   wrAcc && addr == RA_EN_LO};
  assign stb.wrPort = {wrAcc && addr == RA_PORT_HI, wrAcc && addr == RA_PORT_LO};
  assign stb.rdStb  = busSel && !busWr;

  for (genvar g = 0; g < N_GROUPS; g++) begin : g_fire
    assign stb.grpFire[g] = live && cmpStrobe[trigCtl[g*SEL_W +: SEL_W]];
  end
endmodule

// File: rtl/cmp_pattern_dpath.sv
module cmp_pattern_dpath
  import cmp_pattern_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  ctrlStbT                   stb,
  input  logic [ADDR_W-1:0]         busAddr,
  input  logic [BYTE_W-1:0]         busWdata,
  input  logic [N_GROUPS*SEL_W-1:0] trigCtl,
  output logic [N_BITS-1:0]         nextBits,
  output logic [N_BITS-1:0]         enBits,
  output logic [N_BITS-1:0]         portBits,
  output logic [BYTE_W-1:0]         rdData
);
  logic [BYTE_W-1:0] rdMux;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nextBits <= '0;
      enBits   <= '0;
      portBits <= '0;
    end else begin
      for (int b = 0; b < N_BYTES; b++) begin
        if (stb.wrNext[b]) nextBits[b*BYTE_W +: BYTE_W] <= busWdata;
        if (stb.wrEn[b])   enBits[b*BYTE_W +: BYTE_W]   <= busWdata;
      end
      for (int i = 0; i < N_BITS; i++) begin
        if (stb.grpFire[i/GRP_W] && enBits[i]) begin
          portBits[i] <= nextBits[i];
        end else if (stb.wrPort[i/BYTE_W]) begin
          portBits[i] <= busWdata[i%BYTE_W];
        end
      end
    end
  end

  always_comb begin
    rdMux = '0;
    case (regAddrE'(busAddr))
      RA_NEXT_LO: rdMux = nextBits[BYTE_W-1:0];
      RA_NEXT_HI: rdMux = nextBits[N_BITS-1:BYTE_W];
      RA_EN_LO:   rdMux = enBits[BYTE_W-1:0];
      RA_EN_HI:   rdMux = enBits[N_BITS-1:BYTE_W];
      RA_TRIG:    rdMux = BYTE_W'(trigCtl);
      RA_PORT_LO: rdMux = portBits[BYTE_W-1:0];
      RA_PORT_HI: rdMux = portBits[N_BITS-1:BYTE_W];
      default:    rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (stb.rdStb) begin
      rdData <= rdMux;
    end
  end
endmodule

// File: rtl/cmp_pattern_out.sv
module cmp_pattern_out
  import cmp_pattern_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                standby,
  input  logic                busSel,
  input  logic                busWr,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [BYTE_W-1:0]   busWdata,
  output logic [BYTE_W-1:0]   busRdata,
  input  logic [N_STROBE-1:0] cmpStrobe,
  output logic [N_BITS-1:0]   patOut
);
  ctrlStbT                   stb;
  logic [N_GROUPS*SEL_W-1:0] trigCtl;
  logic [N_BITS-1:0]         nextBits;
  logic [N_BITS-1:0]         enBits;

  cmp_pattern_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .standby   (standby),
    .busSel    (busSel),
    .busWr     (busWr),
    .busAddr   (busAddr),
    .busWdata  (busWdata),
    .cmpStrobe (cmpStrobe),
    .stb       (stb),
    .trigCtl   (trigCtl)
  );

  cmp_pattern_dpath u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .trigCtl  (trigCtl),
    .nextBits (nextBits),
    .enBits   (enBits),
    .portBits (patOut),
    .rdData   (busRdata)
  );
endmodule

// File: rtl/cmp_pattern_chk.sv
module cmp_pattern_chk
  import cmp_pattern_pkg::*;
(
  input logic                      clk,
  input logic                      rstN,
  input logic                      standby,
  input logic                      busSel,
  input logic                      busWr,
  input logic [ADDR_W-1:0]         busAddr,
  input logic [BYTE_W-1:0]         busWdata,
  input logic [BYTE_W-1:0]         busRdata,
  input logic [N_STROBE-1:0]       cmpStrobe,
  input logic [N_BITS-1:0]         patOut,
  input logic [N_BITS-1:0]         nextBits,
  input logic [N_BITS-1:0]         enBits,
  input logic [N_GROUPS*SEL_W-1:0] trigCtl
);
  logic [N_BITS-1:0] xferMask;
  logic [N_BITS-1:0] wrMask;
  logic [N_BITS-1:0] wide;

  always_comb begin
    for (int i = 0; i < N_BITS; i++) begin
      xferMask[i] = !standby && enBits[i]
                    && cmpStrobe[trigCtl[(i/GRP_W)*SEL_W +: SEL_W]];
    end
    wrMask = '0;
    if (busSel && busWr && !standby) begin
      if (busAddr == 3'd5) wrMask[BYTE_W-1:0]      = '1;
      if (busAddr == 3'd6) wrMask[N_BITS-1:BYTE_W] = '1;
    end
    wide = {busWdata, busWdata};
  end

  // R2: enabled bits on a fired group take next-data
  a_r2_transfer: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((patOut & $past(xferMask)) == ($past(nextBits) & $past(xferMask))));

  // R3: untouched bits keep their value
  a_r3_hold: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((patOut & ~$past(xferMask | wrMask)) ==
              ($past(patOut) & ~$past(xferMask | wrMask))));

  // R6: bus write lands on the bits without a transfer
  a_r6_write_rest: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((patOut & $past(wrMask & ~xferMask)) ==
              ($past(wide) & $past(wrMask & ~xferMask))));

  // R7: standby freezes all state
  a_r7_standby_freeze: assert property (@(posedge clk) disable iff (!rstN)
    standby |=> ($stable(enBits) && $stable(nextBits) &&
                 $stable(trigCtl) && $stable(patOut)));

  // R5: enable-low read returns contents one cycle later
  a_r5_read_en: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWr && busAddr == 3'd2) |=> (busRdata == $past(enBits[BYTE_W-1:0])));
endmodule

bind cmp_pattern_out cmp_pattern_chk u_chk (.*);

// File: tb/test_cmp_pattern_out.sv
module test_cmp_pattern_out;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        standby = 1'b0;
  logic        busSel = 1'b0;
  logic        busWr = 1'b0;
  logic [2:0]  busAddr = '0;
  logic [7:0]  busWdata = '0;
  logic [7:0]  busRdata;
  logic [3:0]  cmpStrobe = '0;
  logic [15:0] patOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cmp_pattern_out i_cmp_pattern_out (
    .clk(clk), .rstN(rstN), .standby(standby), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .cmpStrobe(cmpStrobe), .patOut(patOut)
  );

  // {kind, req, addr, data, expected}; kind 0 write, 1 strobe, 2 check patOut
  localparam int NV = 27;
  localparam logic [32:0] VEC [NV] = '{
    {2'd0, 4'd4, 3'd4, 8'hE4, 16'h0000},
    {2'd0, 4'd2, 3'd0, 8'hA5, 16'h0000},
    {2'd0, 4'd2, 3'd1, 8'h3C, 16'h0000},
    {2'd0, 4'd2, 3'd2, 8'hFF, 16'h0000},
    {2'd0, 4'd2, 3'd3, 8'h0F, 16'h0000},
    {2'd2, 4'd3, 3'd0, 8'h00, 16'h0000},  // R3 nothing fired yet
    {2'd1, 4'd2, 3'd0, 8'h01, 16'h0000},
    {2'd2, 4'd2, 3'd0, 8'h00, 16'h0005},  // R2 group0
    {2'd1, 4'd4, 3'd0, 8'h02, 16'h0000},
    {2'd2, 4'd4, 3'd0, 8'h00, 16'h00A5},  // R4 group1 uses strobe1
    {2'd1, 4'd3, 3'd0, 8'h08, 16'h0000},
    {2'd2, 4'd3, 3'd0, 8'h00, 16'h00A5},  // R3 group3 disabled
    {2'd1, 4'd2, 3'd0, 8'h04, 16'h0000},
    {2'd2, 4'd2, 3'd0, 8'h00, 16'h0CA5},  // R2 group2 high byte
    {2'd0, 4'd2, 3'd0, 8'h00, 16'h0000},
    {2'd0, 4'd3, 3'd2, 8'h0F, 16'h0000},
    {2'd1, 4'd3, 3'd0, 8'h03, 16'h0000},
    {2'd2, 4'd3, 3'd0, 8'h00, 16'h0CA0},  // R3 bits 7:4 held
    {2'd0, 4'd4, 3'd4, 8'h00, 16'h0000},
    {2'd0, 4'd2, 3'd3, 8'hFF, 16'h0000},
    {2'd1, 4'd4, 3'd0, 8'h01, 16'h0000},
    {2'd2, 4'd4, 3'd0, 8'h00, 16'h3CA0},  // R4 all groups on strobe0
    {2'd0, 4'd4, 3'd1, 8'h00, 16'h0000},
    {2'd1, 4'd4, 3'd0, 8'h02, 16'h0000},
    {2'd2, 4'd4, 3'd0, 8'h00, 16'h3CA0},  // R4 unselected strobe ignored
    {2'd0, 4'd6, 3'd5, 8'h5A, 16'h0000},
    {2'd2, 4'd6, 3'd0, 8'h00, 16'h3C5A}   // R6 plain port write
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic busRead(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    @(negedge clk);
    busSel = 1'b0;
    d = busRdata;
  endtask

  task automatic pulse(input logic [3:0] s);
    @(negedge clk);
    cmpStrobe = s;
    @(negedge clk);
    cmpStrobe = '0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    repeat (2) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    @(negedge clk);
    check("R1 patOut after reset", patOut, 16'h0000);
    busRead(3'd3, rd);
    check("R1 enable high after reset", {8'h00, rd}, 16'h0000);

    for (int v = 0; v < NV; v++) begin
      logic [32:0] e;
      e = VEC[v];
      case (e[32:31])
        2'd0: busWrite(e[26:24], e[23:16]);
        2'd1: pulse(e[19:16]);
        default: begin
          @(negedge clk);
          check($sformatf("R%0d vector %0d", e[30:27], v), patOut, e[15:0]);
        end
      endcase
    end

    // R5 read-back and latency
    busRead(3'd2, rd);
    check("R5 read enable low", {8'h00, rd}, 16'h000F);
    busRead(3'd1, rd);
    check("R5 read next high", {8'h00, rd}, 16'h0000);
    busRead(3'd6, rd);
    check("R5 read port high", {8'h00, rd}, 16'h003C);
    busRead(3'd7, rd);
    check("R5 unused address", {8'h00, rd}, 16'h0000);
    @(negedge clk);
    check("R5 rdata held", {8'h00, busRdata}, 16'h0000);

    // R6 collision: port write and transfer in the same cycle
    busWrite(3'd0, 8'hFF);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = 3'd5; busWdata = 8'h00; cmpStrobe = 4'b0001;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0; cmpStrobe = '0;
    check("R6 collision", patOut, 16'h000F);

    // R7 standby freezes
    @(negedge clk);
    standby = 1'b1;
    busWrite(3'd2, 8'h00);
    busWrite(3'd0, 8'h00);
    busWrite(3'd5, 8'hAA);
    pulse(4'b0001);
    @(negedge clk);
    check("R7 patOut in standby", patOut, 16'h000F);
    standby = 1'b0;
    busRead(3'd2, rd);
    check("R7 enable kept", {8'h00, rd}, 16'h000F);
    busRead(3'd0, rd);
    check("R7 next kept", {8'h00, rd}, 16'h00FF);

    // R4 / R5 trigger register readback, then R1 reset clears it
    busWrite(3'd4, 8'hE4);
    busRead(3'd4, rd);
    check("R4 trigger readback", {8'h00, rd}, 16'h00E4);
    doReset();
    @(negedge clk);
    check("R1 patOut after second reset", patOut, 16'h0000);
    busRead(3'd4, rd);
    check("R1 trigger cleared", {8'h00, rd}, 16'h0000);
    busRead(3'd0, rd);
    check("R1 next cleared", {8'h00, rd}, 16'h0000);
    busRead(3'd2, rd);
    check("R1 enable cleared", {8'h00, rd}, 16'h0000);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule